// File: doc/BRIEF.md
# Double-Buffered UART Transmit Controller

This block sends bytes on a UART line. It has one holding slot in front of a serial shift stage. Software writes a character into the holding slot over a small register bus. When the shift stage is idle, the character moves into it and goes out as an 8N1 frame. The bit rate comes from an oversampling tick supplied from outside. While one frame is on the line, the next character can wait in the holding slot, so software has a full frame time to supply more data.

A status/control register shows two flags: the holding slot can take a byte, and both stages are drained. The same register holds two enable bits. The transmit interrupt is triggered by an event. It is raised only when the holding slot frees up while the enable is on, and it is dropped by the next data write or by turning the enable off. Because of this, turning the enable on when the slot is already free gives no request. Software must write a byte (a real or a dummy one) to start the interrupt flow.

A synchronous software reset clears the transmit path and keeps the enable bits. An asynchronous hardware reset clears everything.

Top module: `uart_txbuf_ctrl`

## Requirements
- R1: After a hardware reset, the control register (bus_addr 0) reads 0xC0, txd is 1 and tx_irq is 0. The ready flag is bit 7, the empty flag is bit 6, bits 5..2 read 0, bit 1 is the receive/break interrupt enable and bit 0 is the transmit interrupt enable.
- R2: A write to the holding register (bus_addr 1) clears the ready flag, and the flag reads 0 in the cycle after the write.
- R3: A held character moves into the shift stage on the first clock edge at which the shift stage is idle. The ready flag reads 1 again from that edge on. While a frame is in progress, a held character waits and ready stays 0.
- R4: The empty flag reads 1 only when the holding slot and the shift stage are both empty. It reads 0 whenever either one holds data.
- R5: txd idles at 1. A frame is a start bit of 0, then the 8 data bits LSB first, then a stop bit of 1. Each bit lasts OVERSAMPLE baud ticks (default 16). The line does not change on cycles without a tick. The start bit appears in the cycle after the transfer into the shift stage.
- R6: tx_irq rises only on the edge at which a held character moves to the shift stage while the transmit enable is 1. It then stays high until the next holding-register write or a control write that clears bit 0.
- R7: Turning the transmit enable on, whether for the first time or after turning it off, raises no interrupt, even when the holding slot is already free. Turning it on after a write that has already been transferred also raises no interrupt.
- R8: Control writes change only bits 1 and 0, and both read back as written. Data written to bits 7..2 has no effect on the flags or the reserved bits.
- R9: While soft_rst is high at a clock edge, the frame in progress and any held character are dropped. In the next cycle ready=1, empty=1, txd=1 and tx_irq=0. Both enable bits keep their values.
- R10: The empty flag rising never raises tx_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset of the transmit path |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control/status register, 1 = holding register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data; status word for address 0, zero for address 1 |
| baud_tick | input | 1 | Oversampling tick, one pulse per 1/OVERSAMPLE bit |
| txd | output | 1 | Serial output |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with DATA_W=8 and OVERSAMPLE=4. Shorter frames make it cheap to send all 256 byte values, each one decoded bit by bit at mid-bit. The short bit period also makes it quick to send frames with ticks spaced two and three cycles apart, which tests that the line holds between ticks. With the small frame, the bench also reaches the back-to-back handoff, the enable toggles before and after a write, and soft and hard resets in the middle of a frame, all within a few thousand cycles each.

// File: rtl/txb_pkg.sv
package txb_pkg;

  localparam int CTL_W            = 8;
  localparam int STAT_READY_BIT   = 7;
  localparam int STAT_EMPTY_BIT   = 6;
  localparam int CTL_RXBK_EN_BIT  = 1;
  localparam int CTL_TX_EN_BIT    = 0;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_HOLD = 1'b1
  } txb_sel_e;

  // Packs the flags and enables into the control/status word
  function automatic logic [CTL_W-1:0] pack_status(logic ready, logic empty,
                                                   logic rxbk_en, logic tx_en);
    logic [CTL_W-1:0] w;
    w = '0;
    w[STAT_READY_BIT]  = ready;
    w[STAT_EMPTY_BIT]  = empty;
    w[CTL_RXBK_EN_BIT] = rxbk_en;
    w[CTL_TX_EN_BIT]   = tx_en;
    return w;
  endfunction

endpackage

// File: rtl/txb_holdbuf.sv
module txb_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shifter_busy,
  output logic              ready,
  output logic              load,
  output logic [DATA_W-1:0] load_data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  // Handoff event: slot occupied and shifter free
  assign load      = full_q & ~shifter_busy;
  assign load_data = data_q;
  assign ready     = ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (soft_rst) begin
      full_q <= 1'b0;
    end else if (wr) begin
      full_q <= 1'b1;
      data_q <= wdata;
    end else if (load) begin
      full_q <= 1'b0;
    end
  end

  // R3: an occupied slot drains at the first idle edge
  assert_handoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !shifter_busy && !wr && !soft_rst) |=> ready);

endmodule

// File: rtl/txb_shifter.sv
module txb_shifter #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              baud_tick,
  output logic              busy,
  output logic              txd
);

  localparam int NBITS = DATA_W + 2;
  localparam int IDX_W = $clog2(NBITS);
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              bit_end;

  // Line level for frame position idx: start, data LSB first, stop
  function automatic logic line_level(logic [DATA_W-1:0] d, logic [IDX_W-1:0] idx);
    logic [NBITS-1:0] frame;
    frame = {1'b1, d, 1'b0};
    return frame[idx];
  endfunction

  assign busy    = busy_q;
  assign txd     = busy_q ? line_level(shreg_q, idx_q) : 1'b1;
  assign bit_end = busy_q & baud_tick & (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      shreg_q <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (soft_rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (load && !busy_q) begin
      busy_q  <= 1'b1;
      shreg_q <= load_data;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (busy_q && baud_tick) begin
      if (bit_end) begin
        cnt_q <= '0;
        if (idx_q == IDX_LAST) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5: a start bit follows every transfer
  assert_start_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy_q && !soft_rst) |=> !txd);

  // R5: without a tick the line holds
  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !baud_tick && !soft_rst) |=> $stable(txd));

endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_bits,
  input  logic       data_wr,
  input  logic       load_evt,
  output logic       tx_en,
  output logic       rxbk_en,
  output logic       irq
);

  import txb_pkg::*;

  logic tx_en_q, rxbk_en_q, pend_q;
  logic en_clear;

  assign tx_en    = tx_en_q;
  assign rxbk_en  = rxbk_en_q;
  assign irq      = pend_q;
  assign en_clear = ctrl_wr & ~ctrl_bits[CTL_TX_EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q   <= 1'b0;
      rxbk_en_q <= 1'b0;
    end else if (ctrl_wr) begin
      tx_en_q   <= ctrl_bits[CTL_TX_EN_BIT];
      rxbk_en_q <= ctrl_bits[CTL_RXBK_EN_BIT];
    end
  end

  // Request latch: set by the handoff event, not by the ready level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (soft_rst)            pend_q <= 1'b0;
    else if (data_wr || en_clear) pend_q <= 1'b0;
    else if (load_evt && tx_en_q) pend_q <= 1'b1;
  end

  // R6: every rise of the request comes from an enabled handoff
  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(load_evt && tx_en));

  // R6: request is never seen with the enable off
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !irq);

  // R6: request persists until acknowledged
  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !data_wr && !ctrl_wr && !soft_rst) |=> irq);

endmodule

// File: rtl/uart_txbuf_ctrl.sv
module uart_txbuf_ctrl #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              baud_tick,
  output logic              txd,
  output logic              tx_irq
);

  import txb_pkg::*;

  logic              data_wr, ctrl_wr;
  logic              ready, empty, busy, load_evt;
  logic              tx_en, rxbk_en;
  logic [DATA_W-1:0] load_data;
  logic [CTL_W-1:0]  status;

  assign data_wr = bus_we & (bus_addr == 1'(SEL_HOLD));
  assign ctrl_wr = bus_we & (bus_addr == 1'(SEL_CTRL));
  assign empty   = ready & ~busy;
  assign status  = pack_status(ready, empty, rxbk_en, tx_en);
  assign bus_rdata = (bus_addr == 1'(SEL_CTRL)) ? DATA_W'(status) : '0;

  txb_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .wr           (data_wr),
    .wdata        (bus_wdata),
    .shifter_busy (busy),
    .ready        (ready),
    .load         (load_evt),
    .load_data    (load_data)
  );

  txb_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .load      (load_evt),
    .load_data (load_data),
    .baud_tick (baud_tick),
    .busy      (busy),
    .txd       (txd)
  );

  txb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_bits (bus_wdata[1:0]),
    .data_wr   (data_wr),
    .load_evt  (load_evt),
    .tx_en     (tx_en),
    .rxbk_en   (rxbk_en),
    .irq       (tx_irq)
  );

  // R2: a data write leaves the slot not ready
  assert_ready_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !soft_rst) |=> !ready);

  // R4: empty implies a free slot and an idle line
  assert_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (ready && txd));

  // R9: soft reset returns the transmit path to idle
  assert_soft_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ready && empty && txd && !tx_irq));

endmodule

// File: tb/sim_uart_txbuf_ctrl.sv
module sim_uart_txbuf_ctrl;

  localparam int DW = 8;
  localparam int OS = 4;
  localparam int FRAME_TICKS = (DW + 2) * OS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic          bus_we = 1'b0;
  logic          bus_addr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          baud_tick = 1'b0;
  logic          txd, tx_irq;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  uart_txbuf_ctrl #(.DATA_W(DW), .OVERSAMPLE(OS)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_tick(baud_tick), .txd(txd), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_level(input int d, input int pos);
    if (pos == 0) return 0;
    if (pos > DW) return 1;
    return (d >> (pos - 1)) & 1;
  endfunction

  function automatic int exp_status(input int rdy, input int emp, input int rx, input int tx);
    return rdy * 128 + emp * 64 + rx * 2 + tx;
  endfunction

  task automatic bus_write(input logic addr, input int data);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = addr; bus_wdata = DW'(data);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
  endtask

  // Drives ticks every 'gap' cycles and checks each bit at mid-bit
  task automatic run_frame(input int d, input int gap);
    int ticks = 0;
    int step = 0;
    bit last_tick = 0;
    logic prev = txd;
    while (ticks < FRAME_TICKS) begin
      if (last_tick && (ticks % OS) == OS / 2)
        chk("R5 frame bit", txd, exp_level(d, ticks / OS));
      else if (!last_tick && step > 0 && gap > 1)
        chk("R5 hold without tick", txd, prev);
      prev = txd;
      last_tick = (step % gap) == 0;
      baud_tick = last_tick;
      if (last_tick) ticks++;
      step++;
      @(negedge clk);
    end
    baud_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 status in reset", int'(bus_rdata), 'hC0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", int'(bus_rdata), 'hC0);
    chk("R1 txd idle", txd, 1);
    chk("R1 irq", tx_irq, 0);

    // R7 enabling with a free slot gives no request
    bus_write(1'b0, 'h01);
    chk("R7 enable read", int'(bus_rdata), 'hC1);
    repeat (4) @(negedge clk);
    chk("R7 first enable no irq", tx_irq, 0);

    // Sweep of all byte values
    for (int d = 0; d < 256; d++) begin
      bus_write(1'b1, d);
      chk("R2 ready cleared", int'(bus_rdata[7]), 0);
      chk("R4 empty low with held byte", int'(bus_rdata[6]), 0);
      chk("R6 write acknowledges irq", tx_irq, 0);
      @(negedge clk);
      chk("R3 ready after handoff", int'(bus_rdata[7]), 1);
      chk("R4 empty low while shifting", int'(bus_rdata[6]), 0);
      chk("R6 irq on handoff", tx_irq, 1);
      chk("R5 start bit", txd, 0);
      run_frame(d, 1);
      chk("R4 empty after frame", int'(bus_rdata), 'hC1);
      chk("R5 idle after frame", txd, 1);
    end

    // Back-to-back handoff with sparse ticks
    bus_write(1'b1, 'h96);
    @(negedge clk);
    bus_write(1'b1, 'h3B);
    chk("R3 waiting byte keeps ready low", int'(bus_rdata[7]), 0);
    chk("R6 irq cleared by write", tx_irq, 0);
    run_frame('h96, 2);
    chk("R3 ready still low at frame end", int'(bus_rdata[7]), 0);
    @(negedge clk);
    chk("R3 second handoff", int'(bus_rdata[7]), 1);
    chk("R6 irq on second handoff", tx_irq, 1);
    run_frame('h3B, 3);
    chk("R4 empty after pair", int'(bus_rdata[6]), 1);

    // R6/R7 disable and re-enable
    bus_write(1'b0, 'h00);
    chk("R6 disable drops irq", tx_irq, 0);
    bus_write(1'b0, 'h01);
    repeat (3) @(negedge clk);
    chk("R7 re-enable no irq", tx_irq, 0);
    bus_write(1'b0, 'h00);
    bus_write(1'b1, 'h5A);
    @(negedge clk);
    bus_write(1'b0, 'h01);
    chk("R7 enable after write no irq", tx_irq, 0);
    run_frame('h5A, 2);
    chk("R10 empty rise no irq", tx_irq, 0);
    chk("R10 empty set", int'(bus_rdata[6]), 1);
    repeat (2) @(negedge clk);
    chk("R10 irq stays low", tx_irq, 0);

    // R8 writes to flag and reserved bits ignored
    bus_write(1'b0, 'hFE);
    chk("R8 only enables writable", int'(bus_rdata), exp_status(1, 1, 1, 0));
    bus_write(1'b0, 'h3D);
    chk("R8 enable bits readback", int'(bus_rdata), exp_status(1, 1, 0, 1));
    bus_write(1'b0, 'h03);
    chk("R8 both enables", int'(bus_rdata), exp_status(1, 1, 1, 1));

    // R9 soft reset in mid-frame with a byte waiting
    bus_write(1'b1, 'hA5);
    @(negedge clk);
    bus_write(1'b1, 'hC3);
    baud_tick = 1'b1;
    repeat (7) @(negedge clk);
    baud_tick = 1'b0;
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R9 status after soft reset", int'(bus_rdata), exp_status(1, 1, 1, 1));
    chk("R9 txd after soft reset", txd, 1);
    chk("R9 irq after soft reset", tx_irq, 0);
    repeat (3) @(negedge clk);
    chk("R9 line stays idle", txd, 1);
    bus_write(1'b1, 'h3C);
    @(negedge clk);
    chk("R9 transmit resumes", txd, 0);
    run_frame('h3C, 1);

    // R1 hardware reset during a frame
    bus_write(1'b1, 'hF0);
    @(negedge clk);
    baud_tick = 1'b1;
    repeat (5) @(negedge clk);
    baud_tick = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-frame reset status", int'(bus_rdata), 'hC0);
    chk("R1 mid-frame reset txd", txd, 1);
    chk("R1 mid-frame reset irq", tx_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after release", int'(bus_rdata), 'hC0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule